// File: doc/BRIEF.md
# Character-Mode Text Video Generator

This block paints a 64-column by 25-row screen of text onto a 512 by 400 pixel visible window of a VGA-style raster, clocked at one pixel per clock (20 MHz in the intended system). Two free-running counters walk every pixel position of a 640-clock by 449-line frame. Their bits address an external character store directly, and the code that comes back, together with the scan line inside the current text row, addresses an external glyph store. Each returned 8-pixel glyph slice is loaded into a shift register and clocked out one pixel per clock. Blanking gates the red, green and blue outputs.

Both stores are external and have a synchronous read port with one clock of latency. The generator only reads them. Writing the character store, choosing colours and filling the glyph store are left to the surrounding logic. Because of the two reads and the shifter, every output that describes the screen position (counts, blanking, syncs, frame pulse) is delayed so that it lines up with the pixel being shown.

Top module: `textVgaGen`

## Requirements
- R1: The reported pixel count `pixCount` advances by one per clock from 0 to H_TOTAL-1 (default 639) and then returns to 0.
- R2: The reported line count `lineCount` holds during a line and advances by one when `pixCount` wraps. After V_TOTAL-1 (default 448) it returns to 0.
- R3: When `pixCount` is H_ACTIVE (512) or more, red, green and blue are all low.
- R4: `hSyncN` is low exactly while `pixCount` is at least 528 and below 600, and high otherwise.
- R5: `vSync` is high exactly while `lineCount` is at least 412 and below 414, and low otherwise.
- R6: When `lineCount` is V_ACTIVE (400) or more, red, green and blue are all low.
- R7: `ramAddr` bits 5:0 carry bits 8:3 of the internal pixel position, and bits 10:6 carry bits 8:4 of the internal line position. The internal position runs exactly 3 clocks ahead of `pixCount`/`lineCount`.
- R8: `romAddr` bits 11:4 equal `ramData`, and bits 3:0 are the low four bits of the internal line position one clock earlier (0 = top glyph line, 15 = bottom).
- R9: Inside the visible window, red, green and blue all equal bit (7 - pixCount mod 8) of the glyph byte for the code stored at column pixCount/8 and row lineCount/16, on glyph line lineCount mod 16. Bit 7 is the leftmost pixel of a cell.
- R10: `frameStart` is high for exactly one clock per frame, in the clock where `pixCount` and `lineCount` are both 0.
- R11: While `rst` is high (synchronous, active high), both counts and `ramAddr` are 0, the colour outputs are low, `hSyncN` is high, `vSync` is low and `frameStart` is low. After release, the first 3 clocks are blanked while the fetch pipeline fills.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ramAddr | output | 11 | Character store read address |
| ramData | input | 8 | Character code, valid one clock after its address |
| romAddr | output | 12 | Glyph store read address |
| romData | input | 8 | Glyph slice, valid one clock after its address |
| red | output | 1 | Red pixel |
| green | output | 1 | Green pixel |
| blue | output | 1 | Blue pixel |
| hSyncN | output | 1 | Horizontal sync, active low |
| vSync | output | 1 | Vertical sync, active high |
| frameStart | output | 1 | One-clock pulse at position 0,0 |
| pixCount | output | 10 | Pixel position of the pixel being shown |
| lineCount | output | 9 | Line position of the pixel being shown |

## Verification
A position the internal counters reach in clock n shows up on `ramAddr` in clock n itself and supplies the low bits of `romAddr` in clock n+1. It reaches the colour outputs, both syncs, `frameStart` and the reported counts in clock n+3. The bench counts clocks since reset release and derives each of these three views from that count. It samples on the falling edge, after every register on the way has settled, and the character and glyph stores are modelled with one clock of read latency. The first three clocks after reset are expected blank with counts at zero. To fit whole frames into the run, the bench shrinks the vertical parameters (48 visible lines, sync on lines 52 to 53, 61 lines in all) and keeps the horizontal defaults.

// File: rtl/textVgaPkg.sv
`timescale 1ns/1ps
package textVgaPkg;

  // Character code width and glyph slice width
  localparam int CODE_W     = 8;
  localparam int FONT_W     = 8;
  // log2 of cell width in pixels and of glyph height in lines
  localparam int CELL_BITS  = 3;
  localparam int GLYPH_BITS = 4;
  // Clocks from counter position to shown pixel: RAM read, ROM read, shifter
  localparam int FETCH_LAT  = 3;

  // Strobes from the timing control to the fetch/shift datapath
  typedef struct packed {
    logic                  loadRow;  // parallel-load the shifter at this edge
    logic                  blank;    // shown pixel lies outside the window
    logic [GLYPH_BITS-1:0] scanRow;  // glyph line for the ROM read in flight
  } vgaFetchCtl_t;

endpackage

// File: rtl/textVgaCtrl.sv
`timescale 1ns/1ps
module textVgaCtrl
  import textVgaPkg::*;
#(
  parameter int H_ACTIVE     = 512,
  parameter int H_SYNC_START = 528,
  parameter int H_SYNC_END   = 600,
  parameter int H_TOTAL      = 640,
  parameter int V_ACTIVE     = 400,
  parameter int V_SYNC_START = 412,
  parameter int V_SYNC_END   = 414,
  parameter int V_TOTAL      = 449,
  localparam int PIX_W    = $clog2(H_TOTAL),
  localparam int LINE_W   = $clog2(V_TOTAL),
  localparam int COL_BITS = $clog2(H_ACTIVE) - CELL_BITS,
  localparam int ROW_BITS = LINE_W - GLYPH_BITS
) (
  input  logic                clk,
  input  logic                rst,
  output logic [COL_BITS-1:0] charCol,
  output logic [ROW_BITS-1:0] charRow,
  output vgaFetchCtl_t        fetchCtl,
  output logic                hSyncN,
  output logic                vSync,
  output logic                frameStart,
  output logic [PIX_W-1:0]    shownPix,
  output logic [LINE_W-1:0]   shownLine
);

  localparam int STAGE_W = 1 + LINE_W + PIX_W;

  localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(H_TOTAL - 1);
  localparam logic [PIX_W-1:0]  H_BLANK   = PIX_W'(H_ACTIVE);
  localparam logic [PIX_W-1:0]  HS_ON     = PIX_W'(H_SYNC_START);
  localparam logic [PIX_W-1:0]  HS_OFF    = PIX_W'(H_SYNC_END);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(V_TOTAL - 1);
  localparam logic [LINE_W-1:0] V_BLANK   = LINE_W'(V_ACTIVE);
  localparam logic [LINE_W-1:0] VS_ON     = LINE_W'(V_SYNC_START);
  localparam logic [LINE_W-1:0] VS_OFF    = LINE_W'(V_SYNC_END);

  logic [PIX_W-1:0]  rawPix;
  logic [LINE_W-1:0] rawLine;

  // Frame position counters
  always_ff @(posedge clk) begin
    if (rst) begin
      rawPix  <= '0;
      rawLine <= '0;
    end else if (rawPix == PIX_LAST) begin
      rawPix  <= '0;
      rawLine <= (rawLine == LINE_LAST) ? '0 : rawLine + 1'b1;
    end else begin
      rawPix  <= rawPix + 1'b1;
    end
  end

  // Counter bits go straight into the character address
  assign charCol = rawPix[CELL_BITS +: COL_BITS];
  assign charRow = rawLine[LINE_W-1 -: ROW_BITS];

  // Position history, one entry per fetch stage: {valid, line, pix}
  logic [STAGE_W-1:0] stage [FETCH_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < FETCH_LAT; s++) stage[s] <= '0;
    end else begin
      stage[0] <= {1'b1, rawLine, rawPix};
      for (int s = 1; s < FETCH_LAT; s++) stage[s] <= stage[s-1];
    end
  end

  logic outValid;
  assign {outValid, shownLine, shownPix} = stage[FETCH_LAT-1];

  logic hBlank, vBlank;
  assign hBlank = (shownPix >= H_BLANK);
  assign vBlank = (shownLine >= V_BLANK);

  always_comb begin
    fetchCtl.blank   = !outValid || hBlank || vBlank;
    // Glyph byte for a cell is at the ROM port two clocks after its address
    fetchCtl.loadRow = (stage[1][CELL_BITS-1:0] == '0);
    // RAM data in flight belongs to the position one clock old
    fetchCtl.scanRow = stage[0][PIX_W +: GLYPH_BITS];
  end

  assign hSyncN     = !(outValid && (shownPix >= HS_ON) && (shownPix < HS_OFF));
  assign vSync      = outValid && (shownLine >= VS_ON) && (shownLine < VS_OFF);
  assign frameStart = outValid && (shownPix == '0) && (shownLine == '0);

endmodule

// File: rtl/textVgaData.sv
`timescale 1ns/1ps
module textVgaData
  import textVgaPkg::*;
#(
  parameter int COL_BITS = 6,
  parameter int ROW_BITS = 5,
  localparam int RAM_AW  = ROW_BITS + COL_BITS,
  localparam int ROM_AW  = CODE_W + GLYPH_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [COL_BITS-1:0] charCol,
  input  logic [ROW_BITS-1:0] charRow,
  input  vgaFetchCtl_t        fetchCtl,
  input  logic [CODE_W-1:0]   ramData,
  input  logic [FONT_W-1:0]   romData,
  output logic [RAM_AW-1:0]   ramAddr,
  output logic [ROM_AW-1:0]   romAddr,
  output logic                pixelOn
);

  logic [FONT_W-1:0] rowBits;

  assign ramAddr = {charRow, charCol};
  assign romAddr = {ramData, fetchCtl.scanRow};

  // Glyph slice shifter, leftmost pixel in the top bit
  always_ff @(posedge clk) begin
    if (rst)                   rowBits <= '0;
    else if (fetchCtl.loadRow) rowBits <= romData;
    else                       rowBits <= {rowBits[FONT_W-2:0], 1'b0};
  end

  assign pixelOn = rowBits[FONT_W-1] & ~fetchCtl.blank;

endmodule

// File: rtl/textVgaGen.sv
`timescale 1ns/1ps
module textVgaGen
  import textVgaPkg::*;
#(
  parameter int H_ACTIVE     = 512,
  parameter int H_SYNC_START = 528,
  parameter int H_SYNC_END   = 600,
  parameter int H_TOTAL      = 640,
  parameter int V_ACTIVE     = 400,
  parameter int V_SYNC_START = 412,
  parameter int V_SYNC_END   = 414,
  parameter int V_TOTAL      = 449,
  localparam int PIX_W    = $clog2(H_TOTAL),
  localparam int LINE_W   = $clog2(V_TOTAL),
  localparam int COL_BITS = $clog2(H_ACTIVE) - CELL_BITS,
  localparam int ROW_BITS = LINE_W - GLYPH_BITS,
  localparam int RAM_AW   = ROW_BITS + COL_BITS,
  localparam int ROM_AW   = CODE_W + GLYPH_BITS
) (
  input  logic              clk,
  input  logic              rst,
  output logic [RAM_AW-1:0] ramAddr,
  input  logic [CODE_W-1:0] ramData,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [FONT_W-1:0] romData,
  output logic              red,
  output logic              green,
  output logic              blue,
  output logic              hSyncN,
  output logic              vSync,
  output logic              frameStart,
  output logic [PIX_W-1:0]  pixCount,
  output logic [LINE_W-1:0] lineCount
);

  logic [COL_BITS-1:0] charCol;
  logic [ROW_BITS-1:0] charRow;
  vgaFetchCtl_t        fetchCtl;
  logic                pixelOn;

  textVgaCtrl #(
    .H_ACTIVE(H_ACTIVE), .H_SYNC_START(H_SYNC_START), .H_SYNC_END(H_SYNC_END),
    .H_TOTAL(H_TOTAL), .V_ACTIVE(V_ACTIVE), .V_SYNC_START(V_SYNC_START),
    .V_SYNC_END(V_SYNC_END), .V_TOTAL(V_TOTAL)
  ) uCtrl (
    .clk(clk), .rst(rst), .charCol(charCol), .charRow(charRow),
    .fetchCtl(fetchCtl), .hSyncN(hSyncN), .vSync(vSync),
    .frameStart(frameStart), .shownPix(pixCount), .shownLine(lineCount)
  );

  textVgaData #(
    .COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS)
  ) uData (
    .clk(clk), .rst(rst), .charCol(charCol), .charRow(charRow),
    .fetchCtl(fetchCtl), .ramData(ramData), .romData(romData),
    .ramAddr(ramAddr), .romAddr(romAddr), .pixelOn(pixelOn)
  );

  // Monochrome: all three guns follow the same pixel
  assign red   = pixelOn;
  assign green = pixelOn;
  assign blue  = pixelOn;

endmodule

// File: rtl/textVgaGenChecks.sv
`timescale 1ns/1ps
module textVgaGenChecks #(
  parameter int H_ACTIVE     = 512,
  parameter int H_SYNC_START = 528,
  parameter int H_SYNC_END   = 600,
  parameter int H_TOTAL      = 640,
  parameter int V_ACTIVE     = 400,
  parameter int V_SYNC_START = 412,
  parameter int V_SYNC_END   = 414,
  parameter int V_TOTAL      = 449,
  localparam int PIX_W  = $clog2(H_TOTAL),
  localparam int LINE_W = $clog2(V_TOTAL)
) (
  input logic              clk,
  input logic              rst,
  input logic [PIX_W-1:0]  pixCount,
  input logic [LINE_W-1:0] lineCount,
  input logic              red,
  input logic              green,
  input logic              blue,
  input logic              hSyncN,
  input logic              vSync,
  input logic              frameStart
);

  localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(H_TOTAL - 1);
  localparam logic [PIX_W-1:0]  H_BLANK   = PIX_W'(H_ACTIVE);
  localparam logic [PIX_W-1:0]  HS_ON     = PIX_W'(H_SYNC_START);
  localparam logic [PIX_W-1:0]  HS_OFF    = PIX_W'(H_SYNC_END);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(V_TOTAL - 1);
  localparam logic [LINE_W-1:0] V_BLANK   = LINE_W'(V_ACTIVE);
  localparam logic [LINE_W-1:0] VS_ON     = LINE_W'(V_SYNC_START);
  localparam logic [LINE_W-1:0] VS_OFF    = LINE_W'(V_SYNC_END);

  p_pix_step_r1: assert property (@(posedge clk) disable iff (rst)
    (pixCount != PIX_LAST && pixCount != '0) |=> pixCount == $past(pixCount) + 1'b1);

  p_pix_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (pixCount == PIX_LAST) |=> pixCount == '0);

  p_line_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (pixCount != PIX_LAST) |=> $stable(lineCount));

  p_line_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (pixCount == PIX_LAST && lineCount == LINE_LAST) |=> lineCount == '0);

  p_hblank_dark_r3: assert property (@(posedge clk) disable iff (rst)
    (pixCount >= H_BLANK) |-> !(red || green || blue));

  p_hsync_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(hSyncN) |-> pixCount == HS_ON);

  p_hsync_rise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(hSyncN) |-> pixCount == HS_OFF);

  p_vsync_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vSync) |-> (lineCount == VS_ON && pixCount == '0));

  p_vsync_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(vSync) |-> (lineCount == VS_OFF && pixCount == '0));

  p_vblank_dark_r6: assert property (@(posedge clk) disable iff (rst)
    (lineCount >= V_BLANK) |-> !(red || green || blue));

  p_frame_origin_r10: assert property (@(posedge clk) disable iff (rst)
    frameStart |-> (pixCount == '0 && lineCount == '0));

  p_frame_single_r10: assert property (@(posedge clk) disable iff (rst)
    frameStart |=> !frameStart);

endmodule

bind textVgaGen textVgaGenChecks #(
  .H_ACTIVE(H_ACTIVE), .H_SYNC_START(H_SYNC_START), .H_SYNC_END(H_SYNC_END),
  .H_TOTAL(H_TOTAL), .V_ACTIVE(V_ACTIVE), .V_SYNC_START(V_SYNC_START),
  .V_SYNC_END(V_SYNC_END), .V_TOTAL(V_TOTAL)
) uChecks (
  .clk(clk), .rst(rst), .pixCount(pixCount), .lineCount(lineCount),
  .red(red), .green(green), .blue(blue), .hSyncN(hSyncN), .vSync(vSync),
  .frameStart(frameStart)
);

// File: tb/sim_textVgaGen.sv
`timescale 1ns/1ps
module sim_textVgaGen;

  localparam int HA  = 512;
  localparam int HSS = 528;
  localparam int HSE = 600;
  localparam int HT  = 640;
  localparam int VA  = 48;
  localparam int VSS = 52;
  localparam int VSE = 54;
  localparam int VT  = 61;
  localparam int PW   = $clog2(HT);
  localparam int LW   = $clog2(VT);
  localparam int RAW  = (LW - 4) + ($clog2(HA) - 3);
  localparam int ROMW = 12;
  localparam int FRAME = HT * VT;
  localparam int LAT  = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [RAW-1:0]  ramAddr;
  logic [7:0]      ramData;
  logic [ROMW-1:0] romAddr;
  logic [7:0]      romData;
  logic            red, green, blue, hSyncN, vSync, frameStart;
  logic [PW-1:0]   pixCount;
  logic [LW-1:0]   lineCount;

  always #4 clk = ~clk;

  textVgaGen #(
    .H_ACTIVE(HA), .H_SYNC_START(HSS), .H_SYNC_END(HSE), .H_TOTAL(HT),
    .V_ACTIVE(VA), .V_SYNC_START(VSS), .V_SYNC_END(VSE), .V_TOTAL(VT)
  ) u0 (
    .clk(clk), .rst(rst), .ramAddr(ramAddr), .ramData(ramData),
    .romAddr(romAddr), .romData(romData), .red(red), .green(green),
    .blue(blue), .hSyncN(hSyncN), .vSync(vSync), .frameStart(frameStart),
    .pixCount(pixCount), .lineCount(lineCount)
  );

  // External stores with one clock of read latency
  logic [7:0] ramMem [0:(1<<RAW)-1];
  logic [7:0] romMem [0:(1<<ROMW)-1];

  always @(posedge clk) begin
    ramData <= ramMem[ramAddr];
    romData <= romMem[romAddr];
  end

  // Clocks since reset release
  int unsigned cyc;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int cellIndex(input int pix, input int line);
    return (line / 16) * 64 + (pix / 8) % 64;
  endfunction

  function automatic logic glyphBit(input int pix, input int line);
    logic [7:0] code;
    logic [7:0] slice;
    code  = ramMem[cellIndex(pix, line)];
    slice = romMem[int'(code) * 16 + line % 16];
    return slice[7 - pix % 8];
  endfunction

  task automatic resetChecks();
    chk("R11 pixCount", 32'(pixCount), 0);
    chk("R11 lineCount", 32'(lineCount), 0);
    chk("R11 ramAddr", 32'(ramAddr), 0);
    chk("R11 rgb", 32'({red, green, blue}), 0);
    chk("R11 hSyncN", 32'(hSyncN), 1);
    chk("R11 vSync", 32'(vSync), 0);
    chk("R11 frameStart", 32'(frameStart), 0);
  endtask

  task automatic checkCycle();
    int n, p0, rp, rl, p1, scan, p3, dp, dl;
    bit valid, active;
    logic e;
    string tag;
    n  = int'(cyc);
    p0 = n % FRAME;
    rp = p0 % HT;
    rl = p0 / HT;
    p1 = (n >= 1) ? (n - 1) % FRAME : 0;
    scan = (p1 / HT) % 16;
    valid = (n >= LAT);
    p3 = valid ? (n - LAT) % FRAME : 0;
    dp = p3 % HT;
    dl = p3 / HT;
    // Address paths
    chk("R7 ramAddr", 32'(ramAddr), 32'(cellIndex(rp, rl)));
    chk("R8 romAddr", 32'(romAddr), (32'(ramData) << 4) | 32'(scan));
    // Reported position
    chk("R1 pixCount", 32'(pixCount), 32'(dp));
    chk("R2 lineCount", 32'(lineCount), 32'(dl));
    // Pixel value
    active = valid && dp < HA && dl < VA;
    e = active ? glyphBit(dp, dl) : 1'b0;
    if (valid && dp >= HA)      tag = "R3 rgb";
    else if (valid && dl >= VA) tag = "R6 rgb";
    else if (!valid)            tag = "R11 rgb";
    else                        tag = "R9 rgb";
    chk(tag, 32'({red, green, blue}), 32'({e, e, e}));
    // Syncs and frame marker
    chk("R4 hSyncN", 32'(hSyncN), 32'(!(valid && dp >= HSS && dp < HSE)));
    chk("R5 vSync", 32'(vSync), 32'(valid && dl >= VSS && dl < VSE));
    chk("R10 frameStart", 32'(frameStart), 32'(valid && dp == 0 && dl == 0));
  endtask

  task automatic runChecked(input int cycles);
    repeat (cycles) begin
      @(negedge clk);
      checkCycle();
    end
  endtask

  task automatic applyReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    resetChecks();
    rst = 1'b0;
  endtask

  initial begin
    int extra;
    void'($urandom(32'h5A3C_0917));
    for (int i = 0; i < (1 << RAW); i++)  ramMem[i] = 8'($urandom());
    for (int i = 0; i < (1 << ROMW); i++) romMem[i] = 8'($urandom());
    // Directed cells: leftmost and rightmost columns, last row, single-bit edges
    ramMem[cellIndex(0, 0)]          = 8'hA5;
    ramMem[cellIndex(HA - 8, 0)]     = 8'hA5;
    ramMem[cellIndex(0, VA - 1)]     = 8'h5A;
    ramMem[cellIndex(HA - 8, VA - 1)] = 8'h00;
    romMem[12'hA50] = 8'h80;
    romMem[12'hA51] = 8'h01;
    romMem[12'hA5F] = 8'hFF;
    romMem[12'h5AF] = 8'h81;
    romMem[12'h000] = 8'h00;
    romMem[12'h00F] = 8'hFF;

    applyReset();
    runChecked(2 * FRAME + 700);

    // Reset again from a random point of the frame
    extra = int'($urandom_range(3000, 100));
    runChecked(extra);
    applyReset();
    runChecked(FRAME + 300);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(180000 * 8);
    errors++;
    $display("FAIL watchdog R1 actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule